// File: doc/BRIEF.md
# Code Memory Protection Guard

This block sits between the core's code-access requests and the on-chip code store and decides, once per clock, whether each request may go ahead. The protection strength comes from three non-volatile fuse bits. Each programmed fuse adds one restriction to the level below it. With no fuse programmed, nothing is restricted. The first fuse stops code-table reads issued by externally stored code from reaching internal code, and it blocks programming of the internal store. The second fuse also blocks read-back (verify) of the store. The third fuse also stops any instruction fetch that would run from external memory. A fuse pattern that does not form one of these four stacked levels is treated as the strongest level.

The block also produces the effective value of the external-access strap, which selects where fetches go. While the first fuse is unprogrammed, the strap pin is used live. Once that fuse is programmed, the strap value captured during the most recent system reset is used instead, and later pin changes have no effect until the next reset. Before the first reset after power-up that captured value is undefined. With the effective strap low, every code address is external. With it high, the lowest 4 KiB of code addresses are internal and everything above them is external.

All decisions are registered. Each request pulse produces exactly one grant or one deny on the clock after it is presented.

Top module: `code_lock_guard`

## Requirements
- R1: While reset is asserted, every grant and deny output, `fetch_ext`, `ea_eff` and `prot_level` read 0 on the cycle after the reset edge.
- R2: `prot_level` reports the fuse decode one cycle after the inputs. `lock_bits` bit 0 is the first fuse, bit 1 the second and bit 2 the third, and 1 means programmed. 000→0, 001→1, 011→2, 111→3. Every other pattern gives 3.
- R3: At level 0 every fetch, code-table read, program and verify request is granted.
- R4: A program request is denied at every level of 1 or above.
- R5: A verify request is denied at levels 2 and 3 and granted at levels 0 and 1.
- R6: A code-table read with `movc_from_ext`=1 whose address maps to internal code is denied at levels 1 to 3. Every other code-table read is granted.
- R7: At level 3 a fetch whose address maps to external memory is denied. A fetch that maps to internal memory is granted.
- R8: An address maps to internal code only when the effective strap is 1 and the address is below 0x1000. `fetch_ext` is 1 for a granted or denied fetch that maps to external memory.
- R9: With fuse bit 0 clear, `ea_eff` follows `ea_pin` with one cycle of latency.
- R10: With fuse bit 0 set, `ea_eff` equals the `ea_pin` value present at the last reset cycle. Pin changes after reset do not alter it.
- R11: For each request kind, exactly one of grant and deny is 1 on the cycle after a request, and both are 0 on the cycle after no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| lock_bits | input | 3 | Fuse states, 1 = programmed |
| ea_pin | input | 1 | External-access strap pin |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 16 | Fetch address |
| movc_req | input | 1 | Code-table read request |
| movc_addr | input | 16 | Code-table read address |
| movc_from_ext | input | 1 | Code-table read issued by code running from external memory |
| prog_req | input | 1 | Code-store programming request |
| vfy_req | input | 1 | Code-store verify request |
| fetch_grant | output | 1 | Fetch allowed |
| fetch_deny | output | 1 | Fetch refused |
| fetch_ext | output | 1 | Fetch routed to external memory |
| movc_grant | output | 1 | Code-table read allowed |
| movc_deny | output | 1 | Code-table read refused |
| prog_grant | output | 1 | Programming allowed |
| prog_deny | output | 1 | Programming refused |
| vfy_grant | output | 1 | Verify allowed |
| vfy_deny | output | 1 | Verify refused |
| ea_eff | output | 1 | Effective strap value |
| prot_level | output | 2 | Decoded protection level |

## Verification
The bench runs every one of the eight fuse patterns. For each pattern it tries both strap values at reset and both live strap values afterwards. This separates the live strap from the captured one, and it shows whether undefined patterns fall back to the strongest level. At each setting, requests are issued at addresses on both sides of the 4 KiB boundary and at the ends of the address space. Each is tried with both values of the code-origin flag, so the routing edge and the origin-dependent refusal of code-table reads show up separately. The strap pin is toggled between requests, which exposes any leakage of the live pin into a captured strap.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;
  localparam int FUSE_COUNT = 3;

  typedef enum logic [1:0] {
    LVL_OPEN    = 2'd0,
    LVL_NOWRITE = 2'd1,
    LVL_NOREAD  = 2'd2,
    LVL_SEALED  = 2'd3
  } prot_lvl_e;
endpackage

// File: rtl/lock_level_decode.sv
module lock_level_decode
  import lock_guard_pkg::*;
#(
  parameter int NLOCK = FUSE_COUNT
) (
  input  logic [NLOCK-1:0] lock_bits,
  output prot_lvl_e        level
);
  localparam int CW = $clog2(NLOCK + 1);

  logic [CW-1:0]    ones;
  logic [NLOCK-1:0] thermo;

  // Valid patterns are thermometer codes filled from bit 0 upward.
  always_comb begin
    ones = '0;
    for (int i = 0; i < NLOCK; i++) ones = ones + CW'(lock_bits[i]);
    thermo = '0;
    for (int i = 0; i < NLOCK; i++) thermo[i] = (CW'(i) < ones);
    if (thermo == lock_bits) level = prot_lvl_e'(ones);
    else                     level = LVL_SEALED;
  end
endmodule

// File: rtl/ea_keeper.sv
module ea_keeper (
  input  logic clk,
  input  logic rst,
  input  logic ea_pin,
  input  logic fuse1,
  output logic ea_now
);
  // Captured strap; deliberately left without a reset value so that it
  // holds whatever it powered up with until the first reset loads it.
  logic held;

  always_ff @(posedge clk) begin
    if (rst) held <= ea_pin;
  end

  assign ea_now = fuse1 ? held : ea_pin;
endmodule

// File: rtl/code_route.sv
module code_route #(
  parameter int ADDR_W    = 16,
  parameter int INT_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ea,
  output logic              internal
);
  localparam int INT_AW = $clog2(INT_BYTES);

  assign internal = ea && (addr[ADDR_W-1:INT_AW] == '0);
endmodule

// File: rtl/code_lock_guard.sv
module code_lock_guard
  import lock_guard_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INT_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        lock_bits,
  input  logic              ea_pin,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              movc_req,
  input  logic [ADDR_W-1:0] movc_addr,
  input  logic              movc_from_ext,
  input  logic              prog_req,
  input  logic              vfy_req,
  output logic              fetch_grant,
  output logic              fetch_deny,
  output logic              fetch_ext,
  output logic              movc_grant,
  output logic              movc_deny,
  output logic              prog_grant,
  output logic              prog_deny,
  output logic              vfy_grant,
  output logic              vfy_deny,
  output logic              ea_eff,
  output logic [1:0]        prot_level
);
  localparam int NPORT = 2;

  prot_lvl_e         lvl;
  logic              ea_now;
  logic [ADDR_W-1:0] rt_addr [NPORT];
  logic              rt_int  [NPORT];

  lock_level_decode #(.NLOCK(FUSE_COUNT)) u_dec (
    .lock_bits (lock_bits),
    .level     (lvl)
  );

  ea_keeper u_ea (
    .clk    (clk),
    .rst    (rst),
    .ea_pin (ea_pin),
    .fuse1  (lock_bits[0]),
    .ea_now (ea_now)
  );

  assign rt_addr[0] = fetch_addr;
  assign rt_addr[1] = movc_addr;

  for (genvar g = 0; g < NPORT; g++) begin : g_route
    code_route #(.ADDR_W(ADDR_W), .INT_BYTES(INT_BYTES)) u_rt (
      .addr     (rt_addr[g]),
      .ea       (ea_now),
      .internal (rt_int[g])
    );
  end

  logic allow_fetch, allow_movc, allow_prog, allow_vfy;

  always_comb begin
    allow_fetch = rt_int[0] || (lvl != LVL_SEALED);
    allow_movc  = !(movc_from_ext && rt_int[1] && (lvl != LVL_OPEN));
    allow_prog  = (lvl == LVL_OPEN);
    allow_vfy   = (lvl == LVL_OPEN) || (lvl == LVL_NOWRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_grant <= 1'b0;
      fetch_deny  <= 1'b0;
      fetch_ext   <= 1'b0;
      movc_grant  <= 1'b0;
      movc_deny   <= 1'b0;
      prog_grant  <= 1'b0;
      prog_deny   <= 1'b0;
      vfy_grant   <= 1'b0;
      vfy_deny    <= 1'b0;
      ea_eff      <= 1'b0;
      prot_level  <= 2'd0;
    end else begin
      fetch_grant <= fetch_req && allow_fetch;
      fetch_deny  <= fetch_req && !allow_fetch;
      fetch_ext   <= fetch_req && !rt_int[0];
      movc_grant  <= movc_req && allow_movc;
      movc_deny   <= movc_req && !allow_movc;
      prog_grant  <= prog_req && allow_prog;
      prog_deny   <= prog_req && !allow_prog;
      vfy_grant   <= vfy_req && allow_vfy;
      vfy_deny    <= vfy_req && !allow_vfy;
      ea_eff      <= ea_now;
      prot_level  <= lvl;
    end
  end
endmodule

// File: rtl/code_lock_guard_chk.sv
module code_lock_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] lock_bits,
  input logic       fetch_req,
  input logic       movc_req,
  input logic       prog_req,
  input logic       vfy_req,
  input logic       fetch_grant,
  input logic       fetch_deny,
  input logic       fetch_ext,
  input logic       movc_grant,
  input logic       movc_deny,
  input logic       prog_grant,
  input logic       prog_deny,
  input logic       vfy_grant,
  input logic       vfy_deny,
  input logic       ea_eff,
  input logic [1:0] prot_level
);
  // R11
  fetch_one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fetch_req) && !$past(rst)) |-> (fetch_grant != fetch_deny));

  // R11
  movc_one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(movc_req) && !$past(rst)) |-> (movc_grant != movc_deny));

  // R11
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_grant, prog_deny}) && $onehot0({vfy_grant, vfy_deny}));

  // R4
  prog_open_only_chk: assert property (@(posedge clk) disable iff (rst)
    prog_grant |-> (prot_level == 2'd0));

  // R5
  vfy_low_levels_chk: assert property (@(posedge clk) disable iff (rst)
    vfy_grant |-> (prot_level <= 2'd1));

  // R6
  movc_deny_locked_chk: assert property (@(posedge clk) disable iff (rst)
    movc_deny |-> (prot_level != 2'd0));

  // R7
  fetch_deny_sealed_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_deny |-> (fetch_ext && prot_level == 2'd3));

  // R10
  ea_held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_bits[0] && $past(lock_bits[0]) && !$past(rst)) |=> $stable(ea_eff));
endmodule

bind code_lock_guard code_lock_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .lock_bits   (lock_bits),
  .fetch_req   (fetch_req),
  .movc_req    (movc_req),
  .prog_req    (prog_req),
  .vfy_req     (vfy_req),
  .fetch_grant (fetch_grant),
  .fetch_deny  (fetch_deny),
  .fetch_ext   (fetch_ext),
  .movc_grant  (movc_grant),
  .movc_deny   (movc_deny),
  .prog_grant  (prog_grant),
  .prog_deny   (prog_deny),
  .vfy_grant   (vfy_grant),
  .vfy_deny    (vfy_deny),
  .ea_eff      (ea_eff),
  .prot_level  (prot_level)
);

// File: tb/tb_code_lock_guard.sv
module tb_code_lock_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  lock_bits = 3'b000;
  logic        ea_pin = 1'b0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        movc_req = 1'b0;
  logic [15:0] movc_addr = '0;
  logic        movc_from_ext = 1'b0;
  logic        prog_req = 1'b0;
  logic        vfy_req = 1'b0;
  logic        fetch_grant, fetch_deny, fetch_ext;
  logic        movc_grant, movc_deny, prog_grant, prog_deny;
  logic        vfy_grant, vfy_deny, ea_eff;
  logic [1:0]  prot_level;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  code_lock_guard dut (
    .clk(clk), .rst(rst), .lock_bits(lock_bits), .ea_pin(ea_pin),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .movc_req(movc_req), .movc_addr(movc_addr), .movc_from_ext(movc_from_ext),
    .prog_req(prog_req), .vfy_req(vfy_req),
    .fetch_grant(fetch_grant), .fetch_deny(fetch_deny), .fetch_ext(fetch_ext),
    .movc_grant(movc_grant), .movc_deny(movc_deny),
    .prog_grant(prog_grant), .prog_deny(prog_deny),
    .vfy_grant(vfy_grant), .vfy_deny(vfy_deny),
    .ea_eff(ea_eff), .prot_level(prot_level)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (lock=%b)", tag, act, exp, lock_bits);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  function automatic int level_of(input logic [2:0] lk);
    case (lk)
      3'b000:  return 0;
      3'b001:  return 1;
      3'b011:  return 2;
      3'b111:  return 3;
      default: return 3;
    endcase
  endfunction

  logic [15:0] addrs [6] = '{16'h0000, 16'h0ABC, 16'h0FFF, 16'h1000, 16'h8001, 16'hFFFF};

  initial begin
    for (int lk = 0; lk < 8; lk++) begin
      for (int er = 0; er < 2; er++) begin
        for (int el = 0; el < 2; el++) begin
          int lvl;
          int ea_e;
          @(negedge clk);
          lock_bits = 3'(lk);
          rst = 1'b1;
          ea_pin = 1'(er);
          fetch_req = 0; movc_req = 0; prog_req = 0; vfy_req = 0;
          @(posedge clk); @(posedge clk); @(negedge clk);
          // R1: everything cleared while reset is held
          check("R1 grants/denies", int'({fetch_grant, fetch_deny, movc_grant, movc_deny,
                prog_grant, prog_deny, vfy_grant, vfy_deny, fetch_ext}), 0);
          check("R1 ea_eff", int'(ea_eff), 0);
          check("R1 prot_level", int'(prot_level), 0);
          rst = 1'b0;
          ea_pin = 1'(el);
          @(posedge clk); @(negedge clk);
          lvl = level_of(3'(lk));
          check("R2 prot_level", int'(prot_level), lvl);
          // R9 live pin, R10 captured pin
          ea_e = lk[0] ? er : el;
          check(lk[0] ? "R10 ea_eff captured" : "R9 ea_eff live", int'(ea_eff), ea_e);
          // R11 no request -> no verdicts
          check("R11 idle verdicts", int'({fetch_grant, fetch_deny, movc_grant, movc_deny,
                prog_grant, prog_deny, vfy_grant, vfy_deny}), 0);
          for (int ai = 0; ai < 6; ai++) begin
            for (int src = 0; src < 2; src++) begin
              logic pin_now;
              int   int_f, int_m;
              int   a_f, a_m, a_p, a_v;
              pin_now = 1'(el ^ ai ^ src);
              ea_pin = pin_now;
              fetch_req = 1; fetch_addr = addrs[ai];
              movc_req = 1; movc_addr = addrs[5 - ai]; movc_from_ext = 1'(src);
              prog_req = 1; vfy_req = 1;
              ea_e = lk[0] ? er : int'(pin_now);
              int_f = (ea_e == 1 && addrs[ai] < 16'h1000) ? 1 : 0;
              int_m = (ea_e == 1 && addrs[5 - ai] < 16'h1000) ? 1 : 0;
              a_f = (int_f == 1 || lvl != 3) ? 1 : 0;
              a_m = (src == 1 && int_m == 1 && lvl >= 1) ? 0 : 1;
              a_p = (lvl == 0) ? 1 : 0;
              a_v = (lvl <= 1) ? 1 : 0;
              @(posedge clk); @(negedge clk);
              check(lk[0] ? "R10 ea_eff after pin toggle" : "R9 ea_eff follows pin",
                    int'(ea_eff), ea_e);
              check("R8 fetch_ext routing", int'(fetch_ext), 1 - int_f);
              check(lvl == 3 ? "R7 fetch grant" : "R3 fetch grant", int'(fetch_grant), a_f);
              check("R11 fetch deny", int'(fetch_deny), 1 - a_f);
              check(lvl == 0 ? "R3 movc grant" : "R6 movc grant", int'(movc_grant), a_m);
              check("R6 movc deny", int'(movc_deny), 1 - a_m);
              check(lvl == 0 ? "R3 prog grant" : "R4 prog grant", int'(prog_grant), a_p);
              check("R4 prog deny", int'(prog_deny), 1 - a_p);
              check("R5 verify grant", int'(vfy_grant), a_v);
              check("R5 verify deny", int'(vfy_deny), 1 - a_v);
            end
          end
          fetch_req = 0; movc_req = 0; prog_req = 0; vfy_req = 0;
          @(posedge clk); @(negedge clk);
          check("R11 verdicts clear after last request", int'({fetch_grant, fetch_deny,
                movc_grant, movc_deny, prog_grant, prog_deny, vfy_grant, vfy_deny}), 0);
        end
      end
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule